// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a 32-bit arithmetic unit whose results never wrap. When a result falls outside the range the operation allows, the unit clamps it to the nearest bound. A 4-bit operation code selects the function: signed or unsigned add and subtract, a signed doubling of one operand, or clamping of a value to a programmable bit width. The width clamp works either on the whole word or on two independent 16-bit lanes. The result path is purely combinational, so the output reflects the current inputs in the same cycle.

The only state is a sticky saturation flag. It is built as a two-state machine. In state `FLAG_IDLE` the flag reads 0, and in state `FLAG_HELD` it reads 1.

The machine has four transitions:
- **SET**: an issued operation (`en_i` high) that clamps moves the machine from `FLAG_IDLE` to `FLAG_HELD`.
- **CLEAR**: `clr_i` high with no clamping issued operation in the same cycle moves it from `FLAG_HELD` back to `FLAG_IDLE`.
- **HOLD_IDLE** and **HOLD_SET**: in every other case the machine stays in its current state.

Reset places the machine in `FLAG_IDLE`. Software reads the flag to learn that at least one result since the last clear was clamped.

Top module: `sat_alu`

## Requirements
- R1: With `op_i`=0 the unit adds the operands as signed values. If the exact sum exceeds 0x7FFFFFFF the result is 0x7FFFFFFF. If it is below -0x80000000 the result is 0x80000000. Otherwise the result is the sum.
- R2: With `op_i`=1 the unit computes `a_i`-`b_i` as signed values and clamps to the same two bounds as R1.
- R3: With `op_i`=2 the unit adds the operands as unsigned values and gives 0xFFFFFFFF when the sum exceeds that value. With `op_i`=3 it gives `a_i`-`b_i`, or 0 when `b_i` is greater than `a_i`.
- R4: With `op_i`=4 the unit doubles `a_i` as a signed value. Inputs of 0x40000000 or more give 0x7FFFFFFF. Inputs at or below 0xC0000000 (signed) give 0x80000000, and both of these cases count as clamping. Any other input gives `a_i` shifted left by one.
- R5: With `op_i`=5 and n=`width_i`, signed `a_i` is limited to the range -(2^n) to 2^n-1.
- R6: With `op_i`=6 and n=`width_i`, negative `a_i` gives 0, and values above 2^n-1 give 2^n-1.
- R7: With `op_i`=7 (signed) or `op_i`=8 (unsigned), the low half [15:0] and high half [31:16] of `a_i` are each sign-extended and clamped on their own, using the rules of R5 or R6. n is taken from `width_i[3:0]` only, and bit 4 is ignored. Each result is written back to its own half.
- R8: Any `op_i` from 9 to 15 returns `a_i` unchanged and never counts as clamping.
- R9: When `en_i` is high and the selected operation clamps (in either lane, for R7), `sat_flag_o` reads 1 after the next clock edge. It stays 1 until a cycle with `clr_i` high. A clamping issued operation in the same cycle as `clr_i` leaves the flag at 1.
- R10: While `en_i` is low, a clamping input does not set the flag, and `result_o` still shows the combinational result.
- R11: After reset `sat_flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Operation issued this cycle; only issued operations can set the flag |
| clr_i | input | 1 | Clears the sticky flag |
| op_i | input | 4 | Operation select, encoded as in R1 to R8 |
| a_i | input | 32 | First operand, and the value clamped by the width modes |
| b_i | input | 32 | Second operand |
| width_i | input | 5 | Width n for the width-clamp modes |
| result_o | output | 32 | Combinational result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
The assertions sample the inputs at the rising edge. They assume the operands, the operation code and the width stay stable across that edge, and that reset is the only source of the starting state. The stimulus changes every input only at falling edges and holds it for a full cycle. It releases reset before any operation is issued. The halfword assertion assumes the lane width is taken modulo 16, so the stimulus also drives widths with bit 4 set to confirm that the bit is ignored.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [3:0] {
        OP_SADD  = 4'd0,
        OP_SSUB  = 4'd1,
        OP_UADD  = 4'd2,
        OP_USUB  = 4'd3,
        OP_SDBL  = 4'd4,
        OP_SSATW = 4'd5,
        OP_USATW = 4'd6,
        OP_SSATH = 4'd7,
        OP_USATH = 4'd8
    } sat_op_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         uns,
    output logic [W-1:0] res,
    output logic         clamp
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] raw;
    logic       s_ovf;

    always_comb begin
        raw = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        if (sub)
            s_ovf = (a[W-1] != b[W-1]) && (raw[W-1] != a[W-1]);
        else
            s_ovf = (a[W-1] == b[W-1]) && (raw[W-1] != a[W-1]);

        if (uns) begin
            clamp = raw[W];
            if (raw[W])
                res = sub ? '0 : '1;
            else
                res = raw[W-1:0];
        end else begin
            clamp = s_ovf;
            if (s_ovf)
                res = a[W-1] ? SMIN : SMAX;
            else
                res = raw[W-1:0];
        end
    end
endmodule

// File: rtl/sat_double.sv
module sat_double #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] res,
    output logic         clamp
);
    localparam logic [W-1:0] SMAX   = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN   = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] NEG_EDGE = {2'b11, {(W-2){1'b0}}};

    always_comb begin
        // top two bits disagree: the doubled value leaves the range
        clamp = (a[W-1] ^ a[W-2]) || (a == NEG_EDGE);
        if (clamp)
            res = a[W-1] ? SMIN : SMAX;
        else
            res = {a[W-2:0], 1'b0};
    end
endmodule

// File: rtl/sat_lane.sv
module sat_lane #(
    parameter int W = 32
) (
    input  logic [W-1:0]         val,
    input  logic [$clog2(W)-1:0] n,
    input  logic                 sgn,
    output logic [W-1:0]         res,
    output logic                 clamp
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] limit;

    always_comb begin
        limit = (ONE << n) - ONE;
        res   = val;
        clamp = 1'b0;
        if (sgn) begin
            if (!val[W-1] && (val > limit)) begin
                res   = limit;
                clamp = 1'b1;
            end else if (val[W-1] && ($signed(val) < $signed(~limit))) begin
                res   = ~limit;
                clamp = 1'b1;
            end
        end else begin
            if (val[W-1]) begin
                res   = '0;
                clamp = 1'b1;
            end else if (val > limit) begin
                res   = limit;
                clamp = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      clr_i,
    input  logic [3:0]                op_i,
    input  logic [DATA_W-1:0]         a_i,
    input  logic [DATA_W-1:0]         b_i,
    input  logic [$clog2(DATA_W)-1:0] width_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      sat_flag_o
);
    localparam int LANES  = 2;
    localparam int HALF_W = DATA_W / LANES;
    localparam int HNW    = $clog2(HALF_W);

    sat_op_e     op;
    flag_state_e state_q, state_d;

    logic [DATA_W-1:0] as_res, dbl_res, word_res, half_res;
    logic              as_clamp, dbl_clamp, word_clamp;
    logic [LANES-1:0]  half_clamp;
    logic              clamp_any;

    assign op = sat_op_e'(op_i);

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a     (a_i),
        .b     (b_i),
        .sub   ((op == OP_SSUB) || (op == OP_USUB)),
        .uns   ((op == OP_UADD) || (op == OP_USUB)),
        .res   (as_res),
        .clamp (as_clamp)
    );

    sat_double #(.W(DATA_W)) u_double (
        .a     (a_i),
        .res   (dbl_res),
        .clamp (dbl_clamp)
    );

    sat_lane #(.W(DATA_W)) u_word (
        .val   (a_i),
        .n     (width_i),
        .sgn   (op == OP_SSATW),
        .res   (word_res),
        .clamp (word_clamp)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_half
        sat_lane #(.W(HALF_W)) u_half (
            .val   (a_i[g*HALF_W +: HALF_W]),
            .n     (width_i[HNW-1:0]),
            .sgn   (op == OP_SSATH),
            .res   (half_res[g*HALF_W +: HALF_W]),
            .clamp (half_clamp[g])
        );
    end

    always_comb begin
        case (op)
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB: begin
                result_o  = as_res;
                clamp_any = as_clamp;
            end
            OP_SDBL: begin
                result_o  = dbl_res;
                clamp_any = dbl_clamp;
            end
            OP_SSATW, OP_USATW: begin
                result_o  = word_res;
                clamp_any = word_clamp;
            end
            OP_SSATH, OP_USATH: begin
                result_o  = half_res;
                clamp_any = |half_clamp;
            end
            default: begin
                result_o  = a_i;
                clamp_any = 1'b0;
            end
        endcase
    end

    // sticky flag machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FLAG_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (en_i && clamp_any) state_d = FLAG_HELD;
            FLAG_HELD: if (clr_i && !(en_i && clamp_any)) state_d = FLAG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sat_flag_o = (state_q == FLAG_HELD);
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clamp_any) |=> sat_flag_o); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag_o && !clr_i) |=> sat_flag_o); // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(en_i && clamp_any)) |=> !sat_flag_o); // R9
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !sat_flag_o) |=> !sat_flag_o); // R10
    AST_SADD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 && a_i[DATA_W-1] == b_i[DATA_W-1]) |-> result_o[DATA_W-1] == a_i[DATA_W-1]); // R1
    AST_UADD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |-> result_o >= a_i); // R3
    AST_USUB_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3) |-> result_o <= a_i); // R3
    AST_USATH_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd8) |-> (!result_o[DATA_W-1] && !result_o[HALF_W-1])); // R7
endmodule

// File: tb/sat_alu_test.sv
module sat_alu_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [4:0]  width_i = '0;
    logic [31:0] result_o;
    logic        sat_flag_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit model_flag = 1'b0;

    typedef struct {
        logic [31:0] res;
        bit          flag;
        int          req;
    } item_t;
    item_t q[$];

    always #(CLK_P/2) clk = ~clk;

    sat_alu uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .clr_i(clr_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .width_i(width_i),
        .result_o(result_o), .sat_flag_o(sat_flag_o)
    );

    function automatic void clip(input longint v, input longint lo, input longint hi,
                                 output longint r, output bit c);
        c = 1'b0;
        r = v;
        if (v > hi) begin r = hi; c = 1'b1; end
        else if (v < lo) begin r = lo; c = 1'b1; end
    endfunction

    function automatic void model(input logic [3:0] op, input logic [31:0] a,
                                  input logic [31:0] b, input logic [4:0] w,
                                  output logic [31:0] res, output bit c);
        longint sa, sb, r, r2, hi;
        bit c2;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        c = 1'b0;
        res = a;
        case (op)
            4'd0: begin clip(sa + sb, -64'sd2147483648, 64'sd2147483647, r, c); res = r[31:0]; end
            4'd1: begin clip(sa - sb, -64'sd2147483648, 64'sd2147483647, r, c); res = r[31:0]; end
            4'd2: begin clip(longint'(a) + longint'(b), 0, 64'sd4294967295, r, c); res = r[31:0]; end
            4'd3: begin clip(longint'(a) - longint'(b), 0, 64'sd4294967295, r, c); res = r[31:0]; end
            4'd4: begin clip(2 * sa, -64'sd2147483648, 64'sd2147483647, r, c);
                        if (sa == -64'sd1073741824) c = 1'b1;
                        res = r[31:0]; end
            4'd5: begin hi = (64'sd1 <<< w) - 1; clip(sa, -hi - 1, hi, r, c); res = r[31:0]; end
            4'd6: begin hi = (64'sd1 <<< w) - 1; clip(sa, 0, hi, r, c); res = r[31:0]; end
            4'd7, 4'd8: begin
                hi = (64'sd1 <<< w[3:0]) - 1;
                clip(longint'($signed(a[15:0])), (op == 4'd7) ? -hi - 1 : 0, hi, r, c);
                clip(longint'($signed(a[31:16])), (op == 4'd7) ? -hi - 1 : 0, hi, r2, c2);
                res = {r2[15:0], r[15:0]};
                c = c | c2;
            end
            default: begin res = a; c = 1'b0; end
        endcase
    endfunction

    // driver: apply one operation for a cycle and push the expectation
    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] w, input bit en, input bit clr, input int req);
        item_t it;
        logic [31:0] r;
        bit c;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; width_i = w; en_i = en; clr_i = clr;
        model(op, a, b, w, r, c);
        if (en && c) model_flag = 1'b1;
        else if (clr) model_flag = 1'b0;
        it.res = r; it.flag = model_flag; it.req = req;
        q.push_back(it);
    endtask

    // one issued operation with the flag cleared in the same cycle
    task automatic op1(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] w, input int req);
        drive(op, a, b, w, 1'b1, 1'b1, req);
    endtask

    // monitor: compare result and flag just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (result_o !== it.res || sat_flag_o !== it.flag) begin
                    fails++;
                    $display("FAIL R%0d: result=%h flag=%0b expected result=%h flag=%0b",
                             it.req, result_o, sat_flag_o, it.res, it.flag);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (sat_flag_o !== 1'b0 || result_o !== 32'h0) begin
            fails++;
            $display("FAIL R11: flag=%0b result=%h expected flag=0 result=0", sat_flag_o, result_o);
        end
        rst_n = 1'b1;

        // R1 signed add
        op1(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1);
        op1(4'd0, 32'h80000000, 32'hFFFFFFFF, 5'd0, 1);
        op1(4'd0, 32'h5, 32'hFFFFFFFD, 5'd0, 1);
        op1(4'd0, 32'h7FFFFFFF, 32'h80000000, 5'd0, 1);
        // R2 signed subtract
        op1(4'd1, 32'h80000000, 32'h1, 5'd0, 2);
        op1(4'd1, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 2);
        op1(4'd1, 32'd10, 32'd20, 5'd0, 2);
        // R3 unsigned add and subtract
        op1(4'd2, 32'hFFFFFFF0, 32'h20, 5'd0, 3);
        op1(4'd2, 32'd1, 32'd2, 5'd0, 3);
        op1(4'd3, 32'd5, 32'd7, 5'd0, 3);
        op1(4'd3, 32'd7, 32'd5, 5'd0, 3);
        op1(4'd3, 32'd9, 32'd9, 5'd0, 3);
        // R4 doubling, both bounds
        op1(4'd4, 32'h40000000, 32'h0, 5'd0, 4);
        op1(4'd4, 32'h3FFFFFFF, 32'h0, 5'd0, 4);
        op1(4'd4, 32'hC0000000, 32'h0, 5'd0, 4);
        op1(4'd4, 32'hC0000001, 32'h0, 5'd0, 4);
        op1(4'd4, 32'h80000000, 32'h0, 5'd0, 4);
        // R5 signed word width
        op1(4'd5, 32'd200, 32'h0, 5'd7, 5);
        op1(4'hA - 4'd5, -32'sd300, 32'h0, 5'd7, 5);
        op1(4'd5, 32'd50, 32'h0, 5'd7, 5);
        op1(4'd5, 32'd5, 32'h0, 5'd0, 5);
        op1(4'd5, -32'sd5, 32'h0, 5'd0, 5);
        op1(4'd5, 32'h7FFFFFFF, 32'h0, 5'd31, 5);
        // R6 unsigned word width
        op1(4'd6, 32'hFFFFFFFF, 32'h0, 5'd8, 6);
        op1(4'd6, 32'd300, 32'h0, 5'd8, 6);
        op1(4'd6, 32'd100, 32'h0, 5'd8, 6);
        op1(4'd6, 32'h7FFFFFFF, 32'h0, 5'd31, 6);
        // R7 halfword lanes, width bit 4 ignored
        op1(4'd7, 32'h0100FF00, 32'h0, 5'd3, 7);
        op1(4'd7, 32'h0100FF00, 32'h0, 5'd19, 7);
        op1(4'd7, 32'h0002FFEC, 32'h0, 5'd4, 7);
        op1(4'd7, 32'h00020003, 32'h0, 5'd4, 7);
        op1(4'd8, 32'h80000005, 32'h0, 5'd4, 7);
        op1(4'd8, 32'h7FFF0010, 32'h0, 5'd15, 7);
        op1(4'd8, 32'h00030002, 32'h0, 5'd20, 7);
        // R8 unused codes pass a through
        op1(4'd9, 32'hDEADBEEF, 32'h1, 5'd3, 8);
        op1(4'd15, 32'h80000000, 32'h7, 5'd0, 8);

        // R9 sticky behaviour
        drive(4'd0, 32'h7FFFFFFF, 32'h1, 5'd0, 1'b1, 1'b0, 9);
        drive(4'd0, 32'd1, 32'd1, 5'd0, 1'b1, 1'b0, 9);
        drive(4'd9, 32'd4, 32'd0, 5'd0, 1'b1, 1'b0, 9);
        drive(4'd3, 32'd1, 32'd2, 5'd0, 1'b1, 1'b1, 9);
        drive(4'd2, 32'd1, 32'd2, 5'd0, 1'b1, 1'b1, 9);
        drive(4'd2, 32'd1, 32'd2, 5'd0, 1'b1, 1'b0, 9);
        // R10 idle cycles do not set the flag
        drive(4'd3, 32'd1, 32'd2, 5'd0, 1'b0, 1'b0, 10);
        drive(4'd4, 32'h40000000, 32'd0, 5'd0, 1'b0, 1'b0, 10);
        drive(4'd3, 32'd1, 32'd2, 5'd0, 1'b1, 1'b0, 10);
        drive(4'd0, 32'd0, 32'd0, 5'd0, 1'b0, 1'b1, 10);
        drive(4'd0, 32'd0, 32'd0, 5'd0, 1'b0, 1'b0, 10);

        @(negedge clk);
        en_i = 1'b0; clr_i = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule